// File: doc/BRIEF.md
# Control Endpoint Handshake Engine

This block decides how one USB function control endpoint answers the host, one token at a time. A serial interface engine in front of it has already decoded and validated every packet. That engine presents SETUP, OUT and IN tokens, then the bytes of a received data packet with its PID and byte count, then the host's ACK or a timeout. The engine replies with one response request per transaction: a DATA packet with its PID and length, ACK, NAK or STALL. It also holds a small packet buffer that both the host side and firmware can fill and drain.

Firmware runs the control transfer through a small set of controls. Setting the transmit-ready control offers the loaded bytes on the next IN. The data-end control moves the transfer into its status stage. The force-stall control rejects traffic. Each of these takes a one-cycle strobe. The engine keeps the data toggle itself. During the status stage it answers every IN with a zero-length DATA1 packet until the host acknowledges one. Only then does it raise transmit-complete. Status flags drive a single interrupt line, and firmware clears each flag with its own acknowledge strobe.

Top module: `ctl_ep_engine`

## Requirements
- R1: While `ep_en` is low, tokens, data packets and handshakes are ignored: no response is issued and no flag, count or toggle changes.
- R2: An OUT token followed by a data packet whose PID bit matches the toggle, with no RX flag pending and no forced stall, gets ACK. The bytes are stored in arrival order, the RX-out flag sets, the byte count latches, and the toggle inverts. The RX-out flag stays set until firmware acknowledges it.
- R3: While the RX-out or RX-setup flag is set, an OUT data packet is answered with NAK. The buffer contents and the byte count stay unchanged.
- R4: A SETUP token and its data packet are always answered with ACK. This sets the RX-setup flag and latches the byte count. It also sets the toggle to 1, so the next data response is DATA1, and clears forced stall and data-end.
- R5: An IN token with transmit-ready clear, data-end clear and no forced stall is answered with NAK.
- R6: An IN token with transmit-ready set is answered with DATA. The PID bit equals the toggle, the length equals the number of bytes loaded, and the bytes come out in load order. A host ACK clears transmit-ready, sets transmit-complete and inverts the toggle. A timeout changes nothing, and the next IN resends the same packet.
- R7: With data-end set and transmit-ready clear, every IN is answered with a zero-length DATA1 packet until the host ACKs. That ACK sets transmit-complete, clears data-end and leaves the toggle unchanged.
- R8: With forced stall set, IN tokens and OUT data packets are answered with STALL, and the STALL-sent flag sets.
- R9: `irq` is high exactly when RX-out is set, or RX-setup is set, or transmit-complete is set while transmit-ready is clear.
- R10: Each acknowledge strobe clears its own flag. Acknowledging a set RX flag also empties the buffer.
- R11: An OUT data packet whose PID bit differs from the toggle is answered with ACK, but RX-out stays clear and the toggle does not change.
- R12: The firmware toggle-clear strobe sets the toggle to 0.
- R13: After reset, all flags, the toggle, forced stall, data-end, the byte count and `irq` are 0, and no response is issued.
- R14: A response is a one-cycle `rsp_valid` pulse in the cycle after the IN token or after the data-packet end. Token codes are SETUP=0, OUT=1, IN=2. Response codes are NONE=0, DATA=1, ACK=2, NAK=3, STALL=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_en | input | 1 | Endpoint enable |
| tok_valid | input | 1 | Token strobe |
| tok_kind | input | 2 | Token code (SETUP=0, OUT=1, IN=2) |
| rx_byte_valid | input | 1 | Received data byte strobe |
| rx_byte | input | 8 | Received data byte |
| rx_end | input | 1 | End of received data packet |
| rx_pid1 | input | 1 | Received packet is DATA1 |
| rx_len | input | 5 | Received packet byte count |
| hs_ack | input | 1 | Host ACKed the last IN data |
| hs_timeout | input | 1 | No handshake from host |
| tx_pop | input | 1 | Engine takes one transmit byte |
| tx_byte | output | 8 | Current transmit byte |
| rsp_valid | output | 1 | Response request strobe |
| rsp_kind | output | 3 | Response code |
| rsp_pid1 | output | 1 | DATA response uses DATA1 |
| rsp_len | output | 5 | DATA response length |
| fw_fifo_wr | input | 1 | Firmware buffer write |
| fw_fifo_wdata | input | 8 | Firmware write byte |
| fw_fifo_rd | input | 1 | Firmware buffer read advance |
| fw_fifo_rdata | output | 8 | Firmware read byte |
| fw_set_txrdy | input | 1 | Set transmit-ready |
| fw_set_data_end | input | 1 | Set data-end |
| fw_set_stall | input | 1 | Set forced stall |
| fw_clr_toggle | input | 1 | Clear toggle |
| fw_ack_rx_out | input | 1 | Acknowledge RX-out |
| fw_ack_rx_setup | input | 1 | Acknowledge RX-setup |
| fw_ack_tx_cmp | input | 1 | Acknowledge transmit-complete |
| fw_ack_stall_sent | input | 1 | Acknowledge STALL-sent |
| st_rx_out | output | 1 | RX-out flag |
| st_rx_setup | output | 1 | RX-setup flag |
| st_tx_rdy | output | 1 | Transmit-ready |
| st_tx_cmp | output | 1 | Transmit-complete flag |
| st_stall_sent | output | 1 | STALL-sent flag |
| st_toggle | output | 1 | Data toggle |
| st_force_stall | output | 1 | Forced stall |
| st_data_end | output | 1 | Data-end |
| st_rx_cnt | output | 5 | Latched received byte count |
| irq | output | 1 | Endpoint interrupt |

## Verification
Every cycle, the assertions check the following. A disabled endpoint stays silent. RX-out holds until it is acknowledged and only ever rises with an ACK. A busy OUT never opens the buffer to host bytes. An idle IN gets NAK and a stalled IN gets STALL. A status-stage IN gets a zero-length DATA1. RX-setup rises with toggle 1 and stall cleared. The buffer never counts past its depth. Some behaviour only the bench scenarios can show: the stored and transmitted byte order, the toggle sequence across many transactions, identical retries after a timeout, buffer contents surviving a NAKed packet, and the interrupt line over full transfer sequences.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  typedef enum logic [1:0] {TK_SETUP = 2'd0, TK_OUT = 2'd1, TK_IN = 2'd2} tok_e;
  typedef enum logic [2:0] {
    RS_NONE = 3'd0, RS_DATA = 3'd1, RS_ACK = 3'd2, RS_NAK = 3'd3, RS_STALL = 3'd4
  } rsp_e;
  // what to do with the data packet that follows an OUT or SETUP token
  typedef enum logic [1:0] {AR_IDLE, AR_TAKE, AR_NAK, AR_STALL} arm_e;
  // which IN response is waiting for the host handshake
  typedef enum logic [1:0] {IP_IDLE, IP_DATA, IP_STATUS} pend_e;
endpackage

// File: rtl/ctl_ep_fifo.sv
module ctl_ep_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rewind,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  input  logic             rd_en,
  output logic [DW-1:0]    rdata,
  output logic [CNT_W-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    rptr_q, rptr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             wr_ok;

  always_comb begin
    wr_ok  = wr_en && !clr && (cnt_q < FULL);
    cnt_n  = clr ? '0 : cnt_q + CNT_W'(wr_ok);
    rptr_n = rptr_q;
    if (clr || rewind)  rptr_n = '0;
    else if (rd_en)     rptr_n = rptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rptr_q <= '0;
    end else begin
      cnt_q  <= cnt_n;
      rptr_q <= rptr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[cnt_q[AW-1:0]] <= wdata;
  end

  assign rdata = mem[rptr_q];
  assign level = cnt_q;

  // R2: a full buffer does not grow
  p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL && !clr) |=> cnt_q == FULL);
endmodule

// File: rtl/ctl_ep_ctrl.sv
module ctl_ep_ctrl
  import ctl_ep_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ep_en,
  input  logic             tok_valid,
  input  logic [1:0]       tok_kind,
  input  logic             rx_end,
  input  logic             rx_pid1,
  input  logic [CNT_W-1:0] rx_len,
  input  logic             hs_ack,
  input  logic             hs_timeout,
  input  logic             fw_set_txrdy,
  input  logic             fw_set_data_end,
  input  logic             fw_set_stall,
  input  logic             fw_clr_toggle,
  input  logic             fw_ack_rx_out,
  input  logic             fw_ack_rx_setup,
  input  logic             fw_ack_tx_cmp,
  input  logic             fw_ack_stall_sent,
  input  logic [CNT_W-1:0] fifo_level,
  output logic             rx_take,
  output logic             fifo_clr,
  output logic             fifo_rewind,
  output rsp_e             rsp_kind,
  output logic             rsp_pid1,
  output logic [CNT_W-1:0] rsp_len,
  output logic             rx_out,
  output logic             rx_setup,
  output logic             txrdy,
  output logic             tx_cmp,
  output logic             stall_sent,
  output logic             tog,
  output logic             force_stall,
  output logic             dend,
  output logic [CNT_W-1:0] rx_cnt,
  output logic             irq
);
  arm_e             arm_q, arm_n;
  logic             arm_setup_q, arm_setup_n;
  pend_e            pend_q, pend_n;
  rsp_e             rsp_n;
  logic             pid_n;
  logic [CNT_W-1:0] len_n, cnt_n;
  logic             rxo_n, rxs_n, rdy_n, cmp_n, ss_n, tog_n, fs_n, de_n;

  always_comb begin
    arm_n = arm_q;  arm_setup_n = arm_setup_q;  pend_n = pend_q;
    rsp_n = RS_NONE; pid_n = 1'b0; len_n = '0; cnt_n = rx_cnt;
    rxo_n = rx_out; rxs_n = rx_setup; rdy_n = txrdy; cmp_n = tx_cmp;
    ss_n = stall_sent; tog_n = tog; fs_n = force_stall; de_n = dend;
    fifo_clr = 1'b0; fifo_rewind = 1'b0;

    // firmware strobes; hardware events below take precedence
    if (fw_ack_rx_out)     begin rxo_n = 1'b0; if (rx_out)   fifo_clr = 1'b1; end
    if (fw_ack_rx_setup)   begin rxs_n = 1'b0; if (rx_setup) fifo_clr = 1'b1; end
    if (fw_ack_tx_cmp)     cmp_n = 1'b0;
    if (fw_ack_stall_sent) ss_n  = 1'b0;
    if (fw_set_txrdy)      rdy_n = 1'b1;
    if (fw_set_data_end)   de_n  = 1'b1;
    if (fw_set_stall)      fs_n  = 1'b1;
    if (fw_clr_toggle)     tog_n = 1'b0;

    if (ep_en && tok_valid) begin
      arm_n  = AR_IDLE;
      pend_n = IP_IDLE;
      case (tok_kind)
        TK_SETUP: begin
          arm_n = AR_TAKE; arm_setup_n = 1'b1; fifo_clr = 1'b1;
        end
        TK_OUT: begin
          arm_setup_n = 1'b0;
          if (force_stall)              arm_n = AR_STALL;
          else if (rx_out || rx_setup)  arm_n = AR_NAK;
          else begin arm_n = AR_TAKE; fifo_clr = 1'b1; end
        end
        TK_IN: begin
          if (force_stall) begin
            rsp_n = RS_STALL; ss_n = 1'b1;
          end else if (txrdy) begin
            rsp_n = RS_DATA; pid_n = tog; len_n = fifo_level;
            fifo_rewind = 1'b1; pend_n = IP_DATA;
          end else if (dend) begin
            rsp_n = RS_DATA; pid_n = 1'b1; pend_n = IP_STATUS;
          end else begin
            rsp_n = RS_NAK;
          end
        end
        default: ;
      endcase
    end else if (ep_en && rx_end) begin
      arm_n = AR_IDLE;
      case (arm_q)
        AR_TAKE: begin
          rsp_n = RS_ACK;
          if (arm_setup_q) begin
            rxs_n = 1'b1; cnt_n = rx_len; tog_n = 1'b1; fs_n = 1'b0; de_n = 1'b0;
          end else if (rx_pid1 == tog) begin
            rxo_n = 1'b1; cnt_n = rx_len; tog_n = ~tog;
          end
        end
        AR_NAK:   rsp_n = RS_NAK;
        AR_STALL: begin rsp_n = RS_STALL; ss_n = 1'b1; end
        default:  rsp_n = RS_NONE;
      endcase
    end else if (ep_en && hs_ack) begin
      pend_n = IP_IDLE;
      if (pend_q == IP_DATA) begin
        rdy_n = 1'b0; cmp_n = 1'b1; tog_n = ~tog; fifo_clr = 1'b1;
      end else if (pend_q == IP_STATUS) begin
        cmp_n = 1'b1; de_n = 1'b0;
      end
    end else if (ep_en && hs_timeout) begin
      pend_n = IP_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= AR_IDLE; arm_setup_q <= 1'b0; pend_q <= IP_IDLE;
      rsp_kind <= RS_NONE; rsp_pid1 <= 1'b0; rsp_len <= '0; rx_cnt <= '0;
      rx_out <= 1'b0; rx_setup <= 1'b0; txrdy <= 1'b0; tx_cmp <= 1'b0;
      stall_sent <= 1'b0; tog <= 1'b0; force_stall <= 1'b0; dend <= 1'b0;
    end else begin
      arm_q <= arm_n; arm_setup_q <= arm_setup_n; pend_q <= pend_n;
      rsp_kind <= rsp_n; rsp_pid1 <= pid_n; rsp_len <= len_n; rx_cnt <= cnt_n;
      rx_out <= rxo_n; rx_setup <= rxs_n; txrdy <= rdy_n; tx_cmp <= cmp_n;
      stall_sent <= ss_n; tog <= tog_n; force_stall <= fs_n; dend <= de_n;
    end
  end

  assign rx_take = ep_en && (arm_q == AR_TAKE);
  assign irq     = rx_out || rx_setup || (tx_cmp && !txrdy);

  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_en |=> rsp_kind == RS_NONE);
  p_rxout_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out && !fw_ack_rx_out) |=> rx_out);
  p_rxout_with_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_out) |-> rsp_kind == RS_ACK);
  p_busy_no_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_en && tok_valid && tok_kind == TK_OUT && !force_stall && (rx_out || rx_setup))
      |=> !rx_take);
  p_setup_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_setup) |-> (tog && !force_stall));
  p_in_nak_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_en && tok_valid && tok_kind == TK_IN && !force_stall && !txrdy && !dend)
      |=> rsp_kind == RS_NAK);
  p_status_zlp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_en && tok_valid && tok_kind == TK_IN && !force_stall && !txrdy && dend)
      |=> (rsp_kind == RS_DATA && rsp_pid1 && rsp_len == '0));
  p_in_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_en && tok_valid && tok_kind == TK_IN && force_stall)
      |=> (rsp_kind == RS_STALL && stall_sent));
endmodule

// File: rtl/ctl_ep_engine.sv
module ctl_ep_engine
  import ctl_ep_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ep_en,
  input  logic             tok_valid,
  input  logic [1:0]       tok_kind,
  input  logic             rx_byte_valid,
  input  logic [DW-1:0]    rx_byte,
  input  logic             rx_end,
  input  logic             rx_pid1,
  input  logic [CNT_W-1:0] rx_len,
  input  logic             hs_ack,
  input  logic             hs_timeout,
  input  logic             tx_pop,
  output logic [DW-1:0]    tx_byte,
  output logic             rsp_valid,
  output logic [2:0]       rsp_kind,
  output logic             rsp_pid1,
  output logic [CNT_W-1:0] rsp_len,
  input  logic             fw_fifo_wr,
  input  logic [DW-1:0]    fw_fifo_wdata,
  input  logic             fw_fifo_rd,
  output logic [DW-1:0]    fw_fifo_rdata,
  input  logic             fw_set_txrdy,
  input  logic             fw_set_data_end,
  input  logic             fw_set_stall,
  input  logic             fw_clr_toggle,
  input  logic             fw_ack_rx_out,
  input  logic             fw_ack_rx_setup,
  input  logic             fw_ack_tx_cmp,
  input  logic             fw_ack_stall_sent,
  output logic             st_rx_out,
  output logic             st_rx_setup,
  output logic             st_tx_rdy,
  output logic             st_tx_cmp,
  output logic             st_stall_sent,
  output logic             st_toggle,
  output logic             st_force_stall,
  output logic             st_data_end,
  output logic [CNT_W-1:0] st_rx_cnt,
  output logic             irq
);
  logic             rx_take, fifo_clr, fifo_rewind, host_wr;
  logic [DW-1:0]    fifo_rdata;
  logic [CNT_W-1:0] fifo_level;
  rsp_e             rsp_q;

  assign host_wr = rx_take && rx_byte_valid;

  ctl_ep_fifo #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (fifo_clr),
    .rewind (fifo_rewind),
    .wr_en  (host_wr || fw_fifo_wr),
    .wdata  (host_wr ? rx_byte : fw_fifo_wdata),
    .rd_en  (tx_pop || fw_fifo_rd),
    .rdata  (fifo_rdata),
    .level  (fifo_level)
  );

  ctl_ep_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk               (clk),
    .rst_n             (rst_n),
    .ep_en             (ep_en),
    .tok_valid         (tok_valid),
    .tok_kind          (tok_kind),
    .rx_end            (rx_end),
    .rx_pid1           (rx_pid1),
    .rx_len            (rx_len),
    .hs_ack            (hs_ack),
    .hs_timeout        (hs_timeout),
    .fw_set_txrdy      (fw_set_txrdy),
    .fw_set_data_end   (fw_set_data_end),
    .fw_set_stall      (fw_set_stall),
    .fw_clr_toggle     (fw_clr_toggle),
    .fw_ack_rx_out     (fw_ack_rx_out),
    .fw_ack_rx_setup   (fw_ack_rx_setup),
    .fw_ack_tx_cmp     (fw_ack_tx_cmp),
    .fw_ack_stall_sent (fw_ack_stall_sent),
    .fifo_level        (fifo_level),
    .rx_take           (rx_take),
    .fifo_clr          (fifo_clr),
    .fifo_rewind       (fifo_rewind),
    .rsp_kind          (rsp_q),
    .rsp_pid1          (rsp_pid1),
    .rsp_len           (rsp_len),
    .rx_out            (st_rx_out),
    .rx_setup          (st_rx_setup),
    .txrdy             (st_tx_rdy),
    .tx_cmp            (st_tx_cmp),
    .stall_sent        (st_stall_sent),
    .tog               (st_toggle),
    .force_stall       (st_force_stall),
    .dend              (st_data_end),
    .rx_cnt            (st_rx_cnt),
    .irq               (irq)
  );

  assign rsp_kind      = rsp_q;
  assign rsp_valid     = (rsp_q != RS_NONE);
  assign tx_byte       = fifo_rdata;
  assign fw_fifo_rdata = fifo_rdata;
endmodule

// File: tb/tb_ctl_ep_engine.sv
module tb_ctl_ep_engine;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ep_en, tok_valid, rx_byte_valid, rx_end, rx_pid1, hs_ack, hs_timeout, tx_pop;
  logic [1:0] tok_kind;
  logic [7:0] rx_byte, tx_byte, fw_fifo_wdata, fw_fifo_rdata;
  logic [4:0] rx_len, rsp_len, st_rx_cnt;
  logic rsp_valid, rsp_pid1;
  logic [2:0] rsp_kind;
  logic fw_fifo_wr, fw_fifo_rd, fw_set_txrdy, fw_set_data_end, fw_set_stall, fw_clr_toggle;
  logic fw_ack_rx_out, fw_ack_rx_setup, fw_ack_tx_cmp, fw_ack_stall_sent;
  logic st_rx_out, st_rx_setup, st_tx_rdy, st_tx_cmp, st_stall_sent, st_toggle;
  logic st_force_stall, st_data_end, irq;

  int n_chk = 0, n_fail = 0, exp_tog = 0;
  bit done = 1'b0;

  ctl_ep_engine dut (.*);

  task automatic step(); @(negedge clk); endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int base, input int i);
    return 8'((base + i * 5) & 255);
  endfunction

  task automatic send_tok(input int kind);
    tok_valid = 1'b1; tok_kind = 2'(kind); step(); tok_valid = 1'b0;
  endtask

  task automatic send_data(input int len, input int pid, input int base);
    for (int i = 0; i < len; i++) begin
      rx_byte_valid = 1'b1; rx_byte = pat(base, i); step();
    end
    rx_byte_valid = 1'b0;
    rx_end = 1'b1; rx_pid1 = pid[0]; rx_len = 5'(len); step(); rx_end = 1'b0;
  endtask

  task automatic fw_read(input string req, input int len, input int base);
    for (int i = 0; i < len; i++) begin
      chk(req, fw_fifo_rdata, pat(base, i));
      fw_fifo_rd = 1'b1; step(); fw_fifo_rd = 1'b0;
    end
  endtask

  task automatic tx_read(input string req, input int len, input int base);
    for (int i = 0; i < len; i++) begin
      chk(req, tx_byte, pat(base, i));
      tx_pop = 1'b1; step(); tx_pop = 1'b0;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ep_en = 1'b1; tok_valid = 0; tok_kind = 0; rx_byte_valid = 0; rx_byte = 0;
    rx_end = 0; rx_pid1 = 0; rx_len = 0; hs_ack = 0; hs_timeout = 0; tx_pop = 0;
    fw_fifo_wr = 0; fw_fifo_wdata = 0; fw_fifo_rd = 0; fw_set_txrdy = 0; fw_set_data_end = 0;
    fw_set_stall = 0; fw_clr_toggle = 0; fw_ack_rx_out = 0; fw_ack_rx_setup = 0;
    fw_ack_tx_cmp = 0; fw_ack_stall_sent = 0;
    repeat (3) step();
    rst_n = 1'b1; step();

    // R13 reset state
    chk("R13 rsp", rsp_kind, 0);
    chk("R13 flags", {st_rx_out, st_rx_setup, st_tx_rdy, st_tx_cmp, st_stall_sent,
                      st_toggle, st_force_stall, st_data_end}, 0);
    chk("R13 cnt", st_rx_cnt, 0);
    chk("R13 irq", irq, 0);

    // R1 disabled endpoint ignores everything
    ep_en = 1'b0;
    send_tok(1); send_data(3, 0, 9);
    chk("R1 out rsp", rsp_kind, 0);
    chk("R1 rx_out", st_rx_out, 0);
    chk("R1 cnt", st_rx_cnt, 0);
    send_tok(2);
    chk("R1 in rsp", rsp_valid, 0);
    chk("R1 toggle", st_toggle, 0);
    ep_en = 1'b1;

    // R5 idle IN gets NAK; R14 one-cycle pulse
    send_tok(2);
    chk("R5 nak", rsp_kind, 3);
    chk("R14 valid", rsp_valid, 1);
    step();
    chk("R14 pulse", rsp_valid, 0);

    // R2/R3/R10 sweep over OUT lengths
    for (int len = 0; len <= 8; len++) begin
      send_tok(1); send_data(len, exp_tog, len * 13);
      chk("R2 ack", rsp_kind, 2);
      chk("R2 rx_out", st_rx_out, 1);
      chk("R2 cnt", st_rx_cnt, len);
      chk("R9 irq rx_out", irq, 1);
      exp_tog ^= 1;
      chk("R2 toggle", st_toggle, exp_tog);
      send_tok(1); send_data(len + 1, exp_tog, 200);
      chk("R3 nak", rsp_kind, 3);
      chk("R3 cnt kept", st_rx_cnt, len);
      chk("R3 toggle kept", st_toggle, exp_tog);
      fw_read("R3 R2 data", len, len * 13);
      fw_ack_rx_out = 1'b1; step(); fw_ack_rx_out = 1'b0;
      chk("R10 rx_out ack", st_rx_out, 0);
      chk("R9 irq clear", irq, 0);
    end

    // R11 PID mismatch
    send_tok(1); send_data(2, exp_tog ^ 1, 77);
    chk("R11 ack", rsp_kind, 2);
    chk("R11 rx_out", st_rx_out, 0);
    chk("R11 toggle", st_toggle, exp_tog);

    // R12 toggle clear
    fw_clr_toggle = 1'b1; step(); fw_clr_toggle = 1'b0;
    chk("R12 toggle", st_toggle, 0);
    exp_tog = 0;

    // R8 forced stall on OUT and IN
    fw_set_stall = 1'b1; step(); fw_set_stall = 1'b0;
    chk("R8 force", st_force_stall, 1);
    send_tok(1); send_data(1, 0, 3);
    chk("R8 out stall", rsp_kind, 4);
    chk("R8 stall_sent", st_stall_sent, 1);
    chk("R8 rx_out", st_rx_out, 0);
    fw_ack_stall_sent = 1'b1; step(); fw_ack_stall_sent = 1'b0;
    chk("R10 stall_sent ack", st_stall_sent, 0);
    send_tok(2);
    chk("R8 in stall", rsp_kind, 4);
    step();
    chk("R8 in stall_sent", st_stall_sent, 1);
    fw_ack_stall_sent = 1'b1; step(); fw_ack_stall_sent = 1'b0;

    // R4 SETUP always accepted
    send_tok(0); send_data(8, 0, 50);
    chk("R4 ack", rsp_kind, 2);
    chk("R4 rx_setup", st_rx_setup, 1);
    chk("R4 toggle", st_toggle, 1);
    chk("R4 stall cleared", st_force_stall, 0);
    chk("R4 cnt", st_rx_cnt, 8);
    chk("R9 irq setup", irq, 1);
    send_tok(1); send_data(3, 1, 90);
    chk("R3 nak on setup", rsp_kind, 3);
    fw_read("R4 R3 setup data", 8, 50);
    fw_ack_rx_setup = 1'b1; step(); fw_ack_rx_setup = 1'b0;
    chk("R10 setup ack", st_rx_setup, 0);
    exp_tog = 1;

    // R6 IN data, retry after timeout, ACK
    for (int len = 1; len <= 6; len++) begin
      for (int i = 0; i < len; i++) begin
        fw_fifo_wr = 1'b1; fw_fifo_wdata = pat(len * 7 + 100, i); step();
      end
      fw_fifo_wr = 1'b0;
      fw_set_txrdy = 1'b1; step(); fw_set_txrdy = 1'b0;
      chk("R6 txrdy", st_tx_rdy, 1);
      chk("R9 irq while rdy", irq, 0);
      send_tok(2);
      chk("R6 data", rsp_kind, 1);
      chk("R6 pid", rsp_pid1, exp_tog);
      chk("R6 len", rsp_len, len);
      tx_read("R6 bytes", len, len * 7 + 100);
      hs_timeout = 1'b1; step(); hs_timeout = 1'b0;
      chk("R6 timeout txrdy", st_tx_rdy, 1);
      send_tok(2);
      chk("R6 retry kind", rsp_kind, 1);
      chk("R6 retry pid", rsp_pid1, exp_tog);
      chk("R6 retry len", rsp_len, len);
      tx_read("R6 retry bytes", len, len * 7 + 100);
      hs_ack = 1'b1; step(); hs_ack = 1'b0;
      exp_tog ^= 1;
      chk("R6 txrdy clr", st_tx_rdy, 0);
      chk("R6 tx_cmp", st_tx_cmp, 1);
      chk("R6 toggle", st_toggle, exp_tog);
      chk("R9 irq tx", irq, 1);
      fw_ack_tx_cmp = 1'b1; step(); fw_ack_tx_cmp = 1'b0;
      chk("R10 tx_cmp ack", st_tx_cmp, 0);
    end

    // R7 zero-length status stage
    fw_set_data_end = 1'b1; step(); fw_set_data_end = 1'b0;
    chk("R7 data_end", st_data_end, 1);
    for (int k = 0; k < 2; k++) begin
      send_tok(2);
      chk("R7 kind", rsp_kind, 1);
      chk("R7 pid1", rsp_pid1, 1);
      chk("R7 len0", rsp_len, 0);
      hs_timeout = 1'b1; step(); hs_timeout = 1'b0;
      chk("R7 no cmp yet", st_tx_cmp, 0);
    end
    send_tok(2);
    hs_ack = 1'b1; step(); hs_ack = 1'b0;
    chk("R7 tx_cmp", st_tx_cmp, 1);
    chk("R7 data_end clr", st_data_end, 0);
    chk("R7 toggle kept", st_toggle, exp_tog);
    fw_ack_tx_cmp = 1'b1; step(); fw_ack_tx_cmp = 1'b0;
    send_tok(2);
    chk("R7 R5 after status", rsp_kind, 3);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule